// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command-register controller of a parallel NOR flash device. Each bus write reaches it already decoded as one cycle of address and data. From these writes it follows the multi-cycle unlock and command sequences. It chooses what a read returns: array data from the storage core, a status byte, or identifier codes. It also starts and tracks the embedded program and sector-erase operations.

A program or erase is modelled by a down-counter with a fixed length of cycles per operation. While the counter runs, `busy` stays high, and any write other than an erase suspend has no effect. An erase can be suspended and later resumed. Reads inside the sector being erased then return a fixed status value, and a program may run while the erase is suspended. A test input, `timeout_flag`, forces the running operation into a failed state. Only the reset command clears that state.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset `busy` is 0, `rd_data` is 0 and the controller is in array mode. In that mode a read captures `array_data` into `rd_data` on the edge that samples `rd_en`.
- R2: The program sequence is four writes: data 0xAA at word address low bits 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then the program word at any address. It holds `busy` high for exactly PROG_CYCLES cycles. The controller then returns to array mode.
- R3: A read while a program runs returns a status byte. Bit 7 is the inverse of bit 7 of the program word. Bit 6 is 0 on the first read after the operation starts and inverts on every later read. Bits 5 to 0 are 0.
- R4: A write whose address or data does not match the next step of a sequence returns the controller to array mode. A later program word then starts nothing.
- R5: Data 0xF0 at any address between the cycles of a program, erase or autoselect sequence returns the controller to array mode.
- R6: While an operation runs, 0xF0 is ignored, and `busy` keeps its full length.
- R7: Autoselect is 0xAA@0x555, 0x55@0x2AA, 0x90@0x555. In autoselect, reads at low offset 0 return MFR_ID and reads at offset 1 return DEV_ID, for any sector bits. Only 0xF0 leaves autoselect; every other write, including a whole program sequence, is ignored.
- R8: Sector erase is 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at any address in the sector. The sector is the top SECT_W address bits. `busy` stays high for ERASE_CYCLES cycles. The status byte has bit 7 at 0 and toggles bit 6 as in R3.
- R9: Data 0xB0 during an erase drops `busy` on the next edge. Reads in the erased sector then return 0x80, and reads elsewhere return array data. Data 0x30 at any address resumes the erase for the cycles that remain. The busy cycles before and after the suspend add up to ERASE_CYCLES.
- R10: A program is accepted during an erase suspend and takes PROG_CYCLES cycles. Afterwards the suspended-sector read rule from R9 still applies.
- R11: If `timeout_flag` is high on an edge during an operation, the controller enters a failed state with `busy` at 0. Its reads return status with bit 5 at 1 and bit 7 as in R3, and bit 6 toggles. Only 0xF0 returns the controller to array reads.
- R12: During an erase suspend the erase setup command 0x80 is rejected, and the controller returns to the suspended array mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One decoded command write this cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data of the write; the low 8 bits carry the command |
| rd_en | input | 1 | Read request this cycle |
| rd_addr | input | ADDR_W | Word address of the read |
| array_data | input | DATA_W | Word from the storage core at `rd_addr` |
| timeout_flag | input | 1 | Test input that fails the running operation |
| rd_data | output | DATA_W | Registered read result |
| busy | output | 1 | Embedded program or erase running |

## Verification
The bench builds the block with PROG_CYCLES = 6 and ERASE_CYCLES = 20 and leaves the address width at 15 with a 4-bit sector field. With these short operation lengths the bench can count every busy cycle of a program or erase. It can also split an erase around a suspend and check that the two parts add up. The bench interleaves status reads with these counts, which lets it follow the toggle bit read by read. It can run a complete program inside an erase suspend and then resume the erase.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PROG_WAIT,
        ST_ERS_U0,
        ST_ERS_U1,
        ST_ERS_U2,
        ST_AUTOSEL,
        ST_PROG_RUN,
        ST_ERS_RUN,
        ST_FAIL
    } nor_state_e;

    localparam int UNL_W = 11;
    localparam logic [UNL_W-1:0] UNL_ADDR_A = 11'h555;
    localparam logic [UNL_W-1:0] UNL_ADDR_B = 11'h2AA;

    localparam logic [7:0] CMD_KEY_A   = 8'hAA;
    localparam logic [7:0] CMD_KEY_B   = 8'h55;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;

    typedef struct packed {
        logic unl_a;
        logic unl_b;
        logic at_a;
        logic prog;
        logic ident;
        logic erase;
        logic sector;
        logic rst;
        logic susp;
    } nor_cmd_s;

endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
    import nor_cmd_pkg::*;
(
    input  logic [UNL_W-1:0] addr,
    input  logic [7:0]       op,
    output nor_cmd_s         cmd
);

    logic hit_a;
    logic hit_b;

    assign hit_a = (addr == UNL_ADDR_A);
    assign hit_b = (addr == UNL_ADDR_B);

    always_comb begin
        cmd        = '0;
        cmd.unl_a  = hit_a && (op == CMD_KEY_A);
        cmd.unl_b  = hit_b && (op == CMD_KEY_B);
        cmd.at_a   = hit_a;
        cmd.prog   = (op == CMD_PROG);
        cmd.ident  = (op == CMD_IDENT);
        cmd.erase  = (op == CMD_ERASE);
        cmd.sector = (op == CMD_SECTOR);
        cmd.rst    = (op == CMD_RESET);
        cmd.susp   = (op == CMD_SUSPEND);
    end

endmodule

// File: rtl/nor_op_timer.sv
module nor_op_timer #(
    parameter int unsigned CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic last
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CYCLES[CW-1:0];
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == CW'(1));

endmodule

// File: rtl/nor_read_sel.sv
module nor_read_sel
    import nor_cmd_pkg::*;
#(
    parameter int          ADDR_W = 15,
    parameter int          DATA_W = 8,
    parameter int          SECT_W = 4,
    parameter logic [7:0]  MFR_ID = 8'h5A,
    parameter logic [7:0]  DEV_ID = 8'hA7
) (
    input  nor_state_e          st,
    input  logic                susp,
    input  logic [SECT_W-1:0]   sect,
    input  logic                poll,
    input  logic                tog,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   array_data,
    output logic [DATA_W-1:0]   data
);

    localparam int SECT_LSB = ADDR_W - SECT_W;

    logic [SECT_LSB-1:0] offset;
    logic                in_susp;

    assign offset  = addr[SECT_LSB-1:0];
    assign in_susp = susp && (addr[ADDR_W-1:SECT_LSB] == sect);

    always_comb begin
        data = '0;
        case (st)
            ST_PROG_RUN, ST_ERS_RUN: begin
                data[7:0] = {poll, tog, 6'b0};
            end
            ST_FAIL: begin
                data[7:0] = {poll, tog, 1'b1, 5'b0};
            end
            ST_AUTOSEL: begin
                if (offset == SECT_LSB'(0)) begin
                    data[7:0] = MFR_ID;
                end else if (offset == SECT_LSB'(1)) begin
                    data[7:0] = DEV_ID;
                end
            end
            default: begin
                if (in_susp) begin
                    data[7:0] = 8'h80;
                end else begin
                    data = array_data;
                end
            end
        endcase
    end

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
    import nor_cmd_pkg::*;
#(
    parameter int          ADDR_W       = 15,
    parameter int          DATA_W       = 8,
    parameter int          SECT_W       = 4,
    parameter int unsigned PROG_CYCLES  = 200,
    parameter int unsigned ERASE_CYCLES = 50000,
    parameter logic [7:0]  MFR_ID       = 8'h5A,
    parameter logic [7:0]  DEV_ID       = 8'hA7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_data,
    input  logic              timeout_flag,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);

    localparam int SECT_LSB = ADDR_W - SECT_W;

    typedef struct packed {
        nor_state_e        st;
        logic              susp;
        logic              prog_op;
        logic              pd7;
        logic [SECT_W-1:0] sect;
        logic              tog;
        logic [DATA_W-1:0] rdata;
    } ctl_s;

    ctl_s              d;
    ctl_s              q;
    nor_cmd_s          cmd;
    logic              prog_load;
    logic              ers_load;
    logic              prog_last;
    logic              ers_last;
    logic              poll;
    logic [DATA_W-1:0] rd_sel;
    nor_state_e        st_q;
    logic              tog_q;

    nor_cmd_decode u_dec (
        .addr (wr_addr[UNL_W-1:0]),
        .op   (wr_data[7:0]),
        .cmd  (cmd)
    );

    assign prog_load = wr_en && (q.st == ST_PROG_WAIT) && !cmd.rst;
    assign ers_load  = wr_en && (q.st == ST_ERS_U2) && cmd.sector;

    nor_op_timer #(.CYCLES(PROG_CYCLES)) u_prog_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (prog_load),
        .run   (q.st == ST_PROG_RUN),
        .last  (prog_last)
    );

    nor_op_timer #(.CYCLES(ERASE_CYCLES)) u_ers_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ers_load),
        .run   (q.st == ST_ERS_RUN),
        .last  (ers_last)
    );

    assign poll = q.prog_op ? ~q.pd7 : 1'b0;

    nor_read_sel #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SECT_W (SECT_W),
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID)
    ) u_rsel (
        .st         (q.st),
        .susp       (q.susp),
        .sect       (q.sect),
        .poll       (poll),
        .tog        (q.tog),
        .addr       (rd_addr),
        .array_data (array_data),
        .data       (rd_sel)
    );

    assign busy = (q.st == ST_PROG_RUN) || (q.st == ST_ERS_RUN);

    always_comb begin
        d = q;
        if (rd_en) begin
            d.rdata = rd_sel;
            if (busy || (q.st == ST_FAIL)) begin
                d.tog = ~q.tog;
            end
        end
        case (q.st)
            ST_READ: begin
                if (wr_en) begin
                    if (cmd.unl_a) begin
                        d.st = ST_UNL1;
                    end else if (cmd.sector && q.susp) begin
                        d.st      = ST_ERS_RUN;
                        d.susp    = 1'b0;
                        d.prog_op = 1'b0;
                    end
                end
            end
            ST_UNL1: begin
                if (wr_en) d.st = cmd.unl_b ? ST_UNL2 : ST_READ;
            end
            ST_UNL2: begin
                if (wr_en) begin
                    if (cmd.at_a && cmd.prog) begin
                        d.st = ST_PROG_WAIT;
                    end else if (cmd.at_a && cmd.ident) begin
                        d.st = ST_AUTOSEL;
                    end else if (cmd.at_a && cmd.erase && !q.susp) begin
                        d.st = ST_ERS_U0;
                    end else begin
                        d.st = ST_READ;
                    end
                end
            end
            ST_PROG_WAIT: begin
                if (wr_en) begin
                    if (cmd.rst) begin
                        d.st = ST_READ;
                    end else begin
                        d.st      = ST_PROG_RUN;
                        d.prog_op = 1'b1;
                        d.pd7     = wr_data[7];
                        d.tog     = 1'b0;
                    end
                end
            end
            ST_ERS_U0: begin
                if (wr_en) d.st = cmd.unl_a ? ST_ERS_U1 : ST_READ;
            end
            ST_ERS_U1: begin
                if (wr_en) d.st = cmd.unl_b ? ST_ERS_U2 : ST_READ;
            end
            ST_ERS_U2: begin
                if (wr_en) begin
                    if (cmd.sector) begin
                        d.st      = ST_ERS_RUN;
                        d.sect    = wr_addr[ADDR_W-1:SECT_LSB];
                        d.prog_op = 1'b0;
                        d.tog     = 1'b0;
                    end else begin
                        d.st = ST_READ;
                    end
                end
            end
            ST_AUTOSEL, ST_FAIL: begin
                if (wr_en && cmd.rst) d.st = ST_READ;
            end
            ST_PROG_RUN: begin
                if (timeout_flag) begin
                    d.st = ST_FAIL;
                end else if (prog_last) begin
                    d.st = ST_READ;
                end
            end
            ST_ERS_RUN: begin
                if (timeout_flag) begin
                    d.st = ST_FAIL;
                end else if (ers_last) begin
                    d.st = ST_READ;
                end else if (wr_en && cmd.susp) begin
                    d.st   = ST_READ;
                    d.susp = 1'b1;
                end
            end
            default: begin
                d.st = ST_READ;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_data = q.rdata;
    assign st_q    = q.st;
    assign tog_q   = q.tog;

endmodule

// File: rtl/nor_cmd_ctrl_chk.sv
module nor_cmd_ctrl_chk
    import nor_cmd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [UNL_W-1:0] wr_lo,
    input logic [7:0]       op,
    input logic             rd_en,
    input logic             timeout_flag,
    input logic             busy,
    input nor_state_e       st,
    input logic             tog,
    input logic             prog_last,
    input logic             ers_last
);

    // R2: a program that reaches its last cycle without a timeout returns to array mode
    a_r2_prog_done: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG_RUN && prog_last && !timeout_flag) |=> (st == ST_READ && !busy));

    // R3: each status read while busy flips the toggle bit
    a_r3_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (tog != $past(tog)));

    // R4: a wrong second unlock cycle falls back to array mode
    a_r4_bad_second: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UNL1 && wr_en && !(wr_lo == 11'h2AA && op == 8'h55)) |=> (st == ST_READ));

    // R6: the reset command does not stop a running program
    a_r6_reset_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG_RUN && wr_en && op == 8'hF0 && !timeout_flag && !prog_last)
        |=> (st == ST_PROG_RUN && busy));

    // R7: autoselect is held until a reset command
    a_r7_ident_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_AUTOSEL && !(wr_en && op == 8'hF0)) |=> (st == ST_AUTOSEL));

    // R8: an erase that reaches its last cycle returns to array mode
    a_r8_erase_done: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERS_RUN && ers_last && !timeout_flag) |=> (st == ST_READ && !busy));

    // R9: a suspend during an erase drops busy on the next edge
    a_r9_suspend_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERS_RUN && wr_en && op == 8'hB0 && !ers_last && !timeout_flag)
        |=> (st == ST_READ && !busy));

    // R11: the failed state holds until a reset command and is never busy
    a_r11_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAIL && !(wr_en && op == 8'hF0)) |=> (st == ST_FAIL && !busy));

endmodule

bind nor_cmd_ctrl nor_cmd_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_lo        (wr_addr[10:0]),
    .op           (wr_data[7:0]),
    .rd_en        (rd_en),
    .timeout_flag (timeout_flag),
    .busy         (busy),
    .st           (st_q),
    .tog          (tog_q),
    .prog_last    (prog_last),
    .ers_last     (ers_last)
);

// File: tb/nor_cmd_ctrl_test.sv
`timescale 1ns/1ps
module nor_cmd_ctrl_test;

    localparam int AW = 15;
    localparam int DW = 8;
    localparam int PC = 6;
    localparam int EC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] array_data = '0;
    logic          timeout_flag = 1'b0;
    logic [DW-1:0] rd_data;
    logic          busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    nor_cmd_ctrl #(
        .ADDR_W (AW), .DATA_W (DW), .SECT_W (4),
        .PROG_CYCLES (PC), .ERASE_CYCLES (EC),
        .MFR_ID (8'h5A), .DEV_ID (8'hA7)
    ) uut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_en (rd_en), .rd_addr (rd_addr),
        .array_data (array_data), .timeout_flag (timeout_flag),
        .rd_data (rd_data), .busy (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic unlock();
        wr(15'h555, 8'hAA);
        wr(15'h2AA, 8'h55);
    endtask

    task automatic start_prog(input logic [AW-1:0] a, input logic [7:0] v);
        unlock();
        wr(15'h555, 8'hA0);
        wr(a, v);
    endtask

    task automatic start_erase(input logic [AW-1:0] a);
        unlock();
        wr(15'h555, 8'h80);
        unlock();
        wr(a, 8'h30);
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        array_data = 8'h3C;
        rd(15'h1234, v);
        check(v == 8'h3C, "R1 array read", v, 8'h3C);
        array_data = 8'hC3;
        rd(15'h0007, v);
        check(v == 8'hC3, "R1 array read 2", v, 8'hC3);
    endtask

    task automatic t_program();
        logic [7:0] v;
        int n;
        start_prog(15'h0100, 8'h5A);
        check(busy == 1'b1, "R2 busy start", busy, 1);
        rd(15'h0100, v);
        check(v == 8'h80, "R3 status 1", v, 8'h80);
        rd(15'h0100, v);
        check(v == 8'hC0, "R3 status 2", v, 8'hC0);
        rd(15'h0100, v);
        check(v == 8'h80, "R3 status 3", v, 8'h80);
        count_busy(n);
        check(n + 3 == PC, "R2 busy length", n + 3, PC);
        array_data = 8'h21;
        rd(15'h0100, v);
        check(v == 8'h21, "R2 array after", v, 8'h21);
        start_prog(15'h0200, 8'hA5);
        rd(15'h0200, v);
        check(v == 8'h00, "R3 status msb set", v, 8'h00);
        rd(15'h0200, v);
        check(v == 8'h40, "R3 status toggle", v, 8'h40);
        count_busy(n);
    endtask

    task automatic t_bad_seq();
        logic [7:0] v;
        unlock_bad_addr();
        wr(15'h555, 8'hA0);
        wr(15'h0100, 8'h12);
        check(busy == 1'b0, "R4 bad address", busy, 0);
        unlock();
        wr(15'h555, 8'h77);
        wr(15'h0100, 8'h12);
        check(busy == 1'b0, "R4 bad command", busy, 0);
        array_data = 8'h44;
        rd(15'h0100, v);
        check(v == 8'h44, "R4 array read", v, 8'h44);
    endtask

    task automatic unlock_bad_addr();
        wr(15'h555, 8'hAA);
        wr(15'h2AB, 8'h55);
    endtask

    task automatic t_reset_seq();
        unlock();
        wr(15'h555, 8'hA0);
        wr(15'h7FFF, 8'hF0);
        wr(15'h0100, 8'h12);
        check(busy == 1'b0, "R5 program abort", busy, 0);
        unlock();
        wr(15'h555, 8'h80);
        wr(15'h555, 8'hAA);
        wr(15'h1234, 8'hF0);
        wr(15'h2AA, 8'h55);
        wr(15'h2800, 8'h30);
        check(busy == 1'b0, "R5 erase abort", busy, 0);
    endtask

    task automatic t_reset_busy();
        int n;
        start_prog(15'h0300, 8'h0F);
        check(busy == 1'b1, "R6 busy start", busy, 1);
        wr(15'h0000, 8'hF0);
        count_busy(n);
        check(n + 1 == PC, "R6 length kept", n + 1, PC);
    endtask

    task automatic t_autosel();
        logic [7:0] v;
        unlock();
        wr(15'h555, 8'h90);
        rd(15'h0000, v);
        check(v == 8'h5A, "R7 mfr id", v, 8'h5A);
        rd(15'h0001, v);
        check(v == 8'hA7, "R7 dev id", v, 8'hA7);
        rd(15'h4001, v);
        check(v == 8'hA7, "R7 dev id other sector", v, 8'hA7);
        start_prog(15'h0100, 8'h12);
        check(busy == 1'b0, "R7 program ignored", busy, 0);
        rd(15'h0000, v);
        check(v == 8'h5A, "R7 still ident", v, 8'h5A);
        wr(15'h0000, 8'hF0);
        array_data = 8'h66;
        rd(15'h0000, v);
        check(v == 8'h66, "R7 exit to array", v, 8'h66);
    endtask

    task automatic t_erase();
        logic [7:0] v;
        int n;
        start_erase(15'h2800);
        check(busy == 1'b1, "R8 busy start", busy, 1);
        rd(15'h2800, v);
        check(v == 8'h00, "R8 status 1", v, 8'h00);
        rd(15'h2800, v);
        check(v == 8'h40, "R8 status 2", v, 8'h40);
        count_busy(n);
        check(n + 2 == EC, "R8 busy length", n + 2, EC);
    endtask

    task automatic t_suspend();
        logic [7:0] v;
        int n;
        start_erase(15'h1810);
        repeat (4) @(negedge clk);
        wr(15'h0000, 8'hB0);
        check(busy == 1'b0, "R9 suspend drop", busy, 0);
        array_data = 8'h5C;
        rd(15'h1820, v);
        check(v == 8'h80, "R9 suspended sector", v, 8'h80);
        rd(15'h2000, v);
        check(v == 8'h5C, "R9 other sector", v, 8'h5C);
        start_prog(15'h2000, 8'h11);
        count_busy(n);
        check(n == PC, "R10 program in suspend", n, PC);
        rd(15'h1800, v);
        check(v == 8'h80, "R10 sector rule kept", v, 8'h80);
        rd(15'h0000, v);
        check(v == 8'h5C, "R10 other sector", v, 8'h5C);
        unlock();
        wr(15'h555, 8'h80);
        unlock();
        wr(15'h1800, 8'h30);
        check(busy == 1'b0, "R12 erase rejected", busy, 0);
        rd(15'h1800, v);
        check(v == 8'h80, "R12 still suspended", v, 8'h80);
        wr(15'h0000, 8'h30);
        count_busy(n);
        check(n == EC - 5, "R9 remaining cycles", n, EC - 5);
        array_data = 8'h77;
        rd(15'h1800, v);
        check(v == 8'h77, "R9 sector after resume", v, 8'h77);
    endtask

    task automatic t_timeout();
        logic [7:0] v;
        start_prog(15'h0400, 8'h5A);
        timeout_flag = 1'b1;
        @(negedge clk);
        timeout_flag = 1'b0;
        check(busy == 1'b0, "R11 busy low", busy, 0);
        rd(15'h0400, v);
        check(v == 8'hA0, "R11 status 1", v, 8'hA0);
        rd(15'h0400, v);
        check(v == 8'hE0, "R11 status 2", v, 8'hE0);
        wr(15'h555, 8'hAA);
        rd(15'h0400, v);
        check(v == 8'hA0, "R11 write ignored", v, 8'hA0);
        wr(15'h0300, 8'hF0);
        array_data = 8'h19;
        rd(15'h0400, v);
        check(v == 8'h19, "R11 reset exits", v, 8'h19);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_program();
        t_bad_seq();
        t_reset_seq();
        t_reset_busy();
        t_autosel();
        t_erase();
        t_suspend();
        t_timeout();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule